// File: doc/BRIEF.md
# Hash Message Tail Padder

This block produces the closing words of a message for a 64-byte-block hash core working in MD5 or SHA-1 mode. After the whole data words of a message have been streamed to the core, the caller presents the 0 to 3 bytes that remain, packed low-byte-first in one 32-bit word, together with the total message length in bytes and the algorithm choice. It pulses `start`. The block then emits a stream of 32-bit words under valid/ready flow control: the leftover bytes with the 0x80 end marker merged in, then zero words, then the 64-bit message bit length in two words. The stream ends exactly on a 64-byte block boundary, and it spills into an extra block when the current one has too little room left.

`byte_count` is the full message length, and it includes the leftover bytes. The caller keeps `byte_count mod 4 == tail_bytes`. Bytes of a word are numbered from the least significant end: byte k is bits [8k+7:8k].

Top module: `hash_tail_pad`

## Requirements
- R1: After reset `idle` is 1 and `out_valid` and `out_last` are 0.
- R2: The first emitted word keeps bytes 0..n-1 of `tail_word` (n = `tail_bytes`), holds 0x80 in byte n (also when n is 0), and is zero above byte n.
- R3: With c = `byte_count` mod 64, fill = 64 - c and floor = 8 (n > 0) or 12 (n = 0). If fill < floor, fill is raised by 64. The stream is 3 + (fill - floor)/4 words long, with integer division.
- R4: With `use_sha1` = 1 and L = `byte_count` * 8 as 64 bits, the second-to-last word is L[63:32] byte-reversed and the last word is L[31:0] byte-reversed. This places the length most significant byte first in stream byte order.
- R5: With `use_sha1` = 0, the second-to-last word is L[31:0] and the last word is L[63:32].
- R6: Every word between the first word and the two length words is zero.
- R7: `out_last` is 1 only together with `out_valid` on the final length word.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values into the next cycle.
- R9: A `start` pulse while `idle` is 0 is ignored and leaves the stream in progress unchanged.
- R10: (`byte_count` - n) + 4 * (words emitted) is a multiple of 64, and no stream exceeds 32 words.
- R11: `out_valid` rises the cycle after a `start` accepted while idle, and `idle` returns the cycle after the last word's handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a tail stream (taken only when idle) |
| use_sha1 | input | 1 | 1 = SHA-1 length order, 0 = MD5 length order |
| tail_word | input | 32 | Leftover bytes, byte 0 first |
| tail_bytes | input | 2 | Number of valid leftover bytes (0..3) |
| byte_count | input | CNT_W | Total message length in bytes |
| out_ready | input | 1 | Downstream accepts the current word |
| out_valid | output | 1 | `out_data` holds a tail word |
| out_data | output | 32 | Tail word |
| out_last | output | 1 | Current word is the final one |
| idle | output | 1 | No stream in progress |

## Verification
Inputs are sampled at the rising edge where `start` is seen. The first word is therefore visible one cycle later, and each following word appears one cycle after the handshake on its predecessor. The bench drives and samples on the falling edge: it applies `out_ready`, waits a short settle time, and records a word only when valid and ready are both high in that half-cycle. `idle` is checked at the first falling edge after the handshake on the final word. In the stall patterns, the word seen while ready is low is compared with the word at the next falling edge.

// File: rtl/hpad_pkg.sv
package hpad_pkg;

  localparam int unsigned HP_WORD_W = 32;
  localparam int unsigned HP_BLK_B  = 64;

  // first word: keep low nb bytes, marker byte at position nb
  function automatic logic [HP_WORD_W-1:0] hp_marker(input logic [HP_WORD_W-1:0] w,
                                                    input logic [1:0] nb);
    logic [HP_WORD_W-1:0] keep;
    keep = (32'h1 << {nb, 3'b000}) - 32'h1;
    return (w & keep) | (32'h80 << {nb, 3'b000});
  endfunction

  // zero words between marker word and length pair
  function automatic logic [4:0] hp_zero_words(input logic [5:0] cmod, input logic [1:0] nb);
    logic [7:0] fill;
    logic [7:0] floor_b;
    logic [7:0] gap;
    fill    = 8'(HP_BLK_B) - {2'b00, cmod};
    floor_b = (nb == 2'd0) ? 8'd12 : 8'd8;
    if (fill < floor_b) fill = fill + 8'(HP_BLK_B);
    gap = fill - floor_b;
    return gap[6:2];
  endfunction

  function automatic logic [31:0] hp_bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // returns {first_length_word, second_length_word}
  function automatic logic [63:0] hp_len_pair(input logic [63:0] bits, input logic sha);
    if (sha) return {hp_bswap(bits[63:32]), hp_bswap(bits[31:0])};
    else     return {bits[31:0], bits[63:32]};
  endfunction

endpackage

// File: rtl/hpad_calc.sv
module hpad_calc #(
  parameter int unsigned CNT_W = 61,
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sha,
  input  logic [1:0]       nb,
  input  logic [CNT_W-1:0] cnt,
  input  logic [31:0]      word,
  output logic [31:0]      marker,
  output logic [31:0]      len_first,
  output logic [31:0]      len_second,
  output logic [IDX_W-1:0] n_words
);
  import hpad_pkg::*;

  logic [63:0] bit_len;
  logic [63:0] len_pair;
  logic [4:0]  zeros;

  always_comb begin
    bit_len    = 64'(cnt) << 3;
    len_pair   = hp_len_pair(bit_len, sha);
    len_first  = len_pair[63:32];
    len_second = len_pair[31:0];
    marker     = hp_marker(word, nb);
    zeros      = hp_zero_words(cnt[5:0], nb);
    n_words    = IDX_W'(zeros) + IDX_W'(3);
  end

  p_word_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (n_words <= IDX_W'(32)) && (n_words >= IDX_W'(3)));

endmodule

// File: rtl/hpad_emit.sv
module hpad_emit #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] n_words,
  input  logic [31:0]      marker,
  input  logic [31:0]      len_first,
  input  logic [31:0]      len_second,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [31:0]      out_data,
  output logic             out_last,
  output logic             idle,
  output logic             load
);
  logic             busy;
  logic [IDX_W-1:0] idx;
  logic             beat;
  logic             done_beat;
  logic [IDX_W-1:0] last_idx;
  logic [IDX_W-1:0] len_idx;

  assign last_idx  = n_words - IDX_W'(1);
  assign len_idx   = n_words - IDX_W'(2);
  assign load      = start && !busy;
  assign out_valid = busy;
  assign idle      = !busy;
  assign out_last  = busy && (idx == last_idx);
  assign beat      = out_valid && out_ready;
  assign done_beat = beat && out_last;

  always_comb begin
    if (idx == '0)            out_data = marker;
    else if (idx == len_idx)  out_data = len_first;
    else if (idx == last_idx) out_data = len_second;
    else                      out_data = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (done_beat) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (beat) begin
      idx <= idx + IDX_W'(1);
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx < n_words));

  p_idle_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_beat |=> idle);

  p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_valid_after_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (out_valid && out_data == marker));

endmodule

// File: rtl/hash_tail_pad.sv
module hash_tail_pad #(
  parameter int unsigned CNT_W = 61,
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             use_sha1,
  input  logic [31:0]      tail_word,
  input  logic [1:0]       tail_bytes,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [31:0]      out_data,
  output logic             out_last,
  output logic             idle
);
  logic             sha_q;
  logic [1:0]       nb_q;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      word_q;
  logic             load;
  logic [31:0]      marker;
  logic [31:0]      len_first;
  logic [31:0]      len_second;
  logic [IDX_W-1:0] n_words;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sha_q  <= 1'b0;
      nb_q   <= '0;
      cnt_q  <= '0;
      word_q <= '0;
    end else if (load) begin
      sha_q  <= use_sha1;
      nb_q   <= tail_bytes;
      cnt_q  <= byte_count;
      word_q <= tail_word;
    end
  end

  hpad_calc #(.CNT_W(CNT_W), .IDX_W(IDX_W)) i_calc (
    .clk(clk), .rst_n(rst_n), .sha(sha_q), .nb(nb_q), .cnt(cnt_q), .word(word_q),
    .marker(marker), .len_first(len_first), .len_second(len_second), .n_words(n_words)
  );

  hpad_emit #(.IDX_W(IDX_W)) i_emit (
    .clk(clk), .rst_n(rst_n), .start(start), .n_words(n_words), .marker(marker),
    .len_first(len_first), .len_second(len_second), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .idle(idle),
    .load(load)
  );

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !idle) |=> ($stable(cnt_q) && $stable(word_q) && $stable(sha_q) && $stable(nb_q)));

endmodule

// File: tb/test_hash_tail_pad.sv
`timescale 1ns/1ps
module test_hash_tail_pad;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        use_sha1 = 1'b0;
  logic [31:0] tail_word = '0;
  logic [1:0]  tail_bytes = '0;
  logic [60:0] byte_count = '0;
  logic        out_ready = 1'b0;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_last;
  logic        idle;

  int nchk = 0;
  int nfail = 0;
  logic [31:0] got [0:39];
  logic        got_last [0:39];
  logic [31:0] expw [0:39];

  always #4 clk = ~clk;

  hash_tail_pad i_hash_tail_pad (
    .clk(clk), .rst_n(rst_n), .start(start), .use_sha1(use_sha1), .tail_word(tail_word),
    .tail_bytes(tail_bytes), .byte_count(byte_count), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .idle(idle)
  );

  // {sha, nbytes, count, word}
  localparam logic [95:0] VEC [0:7] = '{
    {1'b1, 2'd0, 61'd0,                  32'hDEADBEEF},
    {1'b0, 2'd1, 61'd1,                  32'h11223344},
    {1'b1, 2'd3, 61'd55,                 32'hAABBCCDD},
    {1'b0, 2'd0, 61'd56,                 32'h01020304},
    {1'b1, 2'd2, 61'd62,                 32'hCAFEF00D},
    {1'b0, 2'd0, 61'd52,                 32'h55555555},
    {1'b1, 2'd0, 61'h1234_5678_9AB0,     32'h0BADC0DE},
    {1'b0, 2'd1, 61'h1FFF_FFFF_FFFF_FFF1, 32'h76543210}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // padded length rounded up from data-before-tail plus marker word plus length
  function automatic int exp_count(input logic [60:0] c, input logic [1:0] nb);
    longint unsigned prior, need, padded;
    prior  = longint'(c) - longint'(nb);
    need   = prior + 12;
    padded = ((need + 63) / 64) * 64;
    return int'((padded - prior) / 4);
  endfunction

  task automatic build_exp(input logic sha, input logic [1:0] nb, input logic [60:0] c,
                           input logic [31:0] w, output int k);
    logic [63:0] bits;
    logic [7:0]  b [0:7];
    logic [31:0] m;
    k = exp_count(c, nb);
    m = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < int'(nb))       m[8*i +: 8] = w[8*i +: 8];
      else if (i == int'(nb)) m[8*i +: 8] = 8'h80;
    end
    expw[0] = m;
    for (int i = 1; i < k - 2; i++) expw[i] = '0;
    bits = {3'b000, c} * 64'd8;
    for (int i = 0; i < 8; i++) b[i] = sha ? bits[63-8*i -: 8] : bits[8*i +: 8];
    expw[k-2] = {b[3], b[2], b[1], b[0]};
    expw[k-1] = {b[7], b[6], b[5], b[4]};
  endtask

  // mode 0: always ready; 1: ready every other cycle; 2: stalls plus start while busy
  task automatic run_case(input logic sha, input logic [1:0] nb, input logic [60:0] c,
                          input logic [31:0] w, input int mode);
    int  n, k, cyc;
    bit  done, hold_pend;
    logic [31:0] held;
    build_exp(sha, nb, c, w, k);
    @(negedge clk);
    use_sha1 = sha; tail_bytes = nb; byte_count = c; tail_word = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(out_valid === 1'b1, "R11 valid one cycle after start", 64'(out_valid), 64'd1);
    n = 0; cyc = 0; done = 0; hold_pend = 0; held = '0;
    while (!done && cyc < 80) begin
      if (hold_pend)
        chk(out_valid === 1'b1 && out_data === held, "R8 stalled word held", 64'(out_data), 64'(held));
      if (mode == 2 && cyc == 2) begin
        start = 1'b1; use_sha1 = ~sha; tail_bytes = nb + 2'd1; byte_count = c + 61'd13;
        tail_word = ~w;
      end else begin
        start = 1'b0;
      end
      out_ready = (mode == 0) ? 1'b1 : cyc[0];
      #1;
      hold_pend = out_valid && !out_ready;
      held = out_data;
      if (out_valid && out_ready && n < 40) begin
        got[n] = out_data; got_last[n] = out_last; n++;
        if (out_last) done = 1;
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0; out_ready = 1'b0;
    chk(idle === 1'b1, "R11 idle after last handshake", 64'(idle), 64'd1);
    chk(n == k, "R3 word count", 64'(n), 64'(k));
    if (n == k) begin
      chk(got[0] === expw[0], "R2 marker word", 64'(got[0]), 64'(expw[0]));
      for (int i = 1; i < k - 2; i++)
        chk(got[i] === 32'd0, "R6 zero fill word", 64'(got[i]), 64'd0);
      chk(got[k-2] === expw[k-2], sha ? "R4 first length word" : "R5 first length word",
          64'(got[k-2]), 64'(expw[k-2]));
      chk(got[k-1] === expw[k-1], sha ? "R4 second length word" : "R5 second length word",
          64'(got[k-1]), 64'(expw[k-1]));
      for (int i = 0; i < k; i++)
        chk(got_last[i] === (i == k - 1), "R7 last flag placement", 64'(got_last[i]), 64'(i == k - 1));
    end
    chk(((longint'(c) - longint'(nb) + 4 * longint'(n)) % 64) == 0 && n <= 32,
        "R10 block multiple and cap", 64'(n), 64'(k));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(idle === 1'b1, "R1 idle after reset", 64'(idle), 64'd1);
    chk(out_valid === 1'b0, "R1 valid low after reset", 64'(out_valid), 64'd0);
    chk(out_last === 1'b0, "R1 last low after reset", 64'(out_last), 64'd0);

    for (int v = 0; v < 8; v++)
      run_case(VEC[v][95], VEC[v][94:93], VEC[v][92:32], VEC[v][31:0], v % 2);

    // R9: start pulses while busy must not disturb the stream
    run_case(1'b1, 2'd2, 61'd6, 32'h89ABCDEF, 2);
    run_case(1'b0, 2'd0, 61'd60, 32'h0, 2);
    // corner: exactly floor room left, nb 3 and nb 0
    run_case(1'b0, 2'd3, 61'd119, 32'hFFFFFFFF, 0);
    run_case(1'b1, 2'd0, 61'd116, 32'h0, 1);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule